// File: doc/BRIEF.md
# Time-of-Day Clock with Shadow Access and Frequency Trim

This block keeps a free-running time of day as 48 bits of seconds and 30 bits of nanoseconds. Every clock it advances the nanoseconds by a fixed step. At one billion nanoseconds it wraps the nanoseconds to zero and carries into the seconds. Software reaches the clock through a small register port. A shadow set holds the upper and lower seconds and the nanoseconds. A one-shot command field then moves time between the shadow and the live counter in either direction, or adds a signed nanosecond offset to the live counter in a single step.

A frequency trim slows or speeds the clock without touching the nominal step. It measures elapsed time in picoseconds or nanoseconds, as the unit bit selects. Each time the programmed interval has elapsed, it inserts or removes one extra nanosecond. An offset can leave the nanosecond field briefly negative or above one second. The next tick repairs this with a borrow from, or a carry into, the seconds. Software applies offsets of up to half a second this way. For larger corrections it reads the time, computes the new value and loads it.

Top module: `ptp_tod_clock`

## Requirements
- R1: While `rst` is high and after it falls, the live seconds and nanoseconds are zero, `rd_data` is zero, and reads of the command, shadow and trim registers return zero.
- R2: With no command pending and no trim correction, each clock adds STEP_NS (default 20) to the nanoseconds and leaves the seconds unchanged.
- R3: When the nanoseconds reach NS_PER_SEC (1e9), they restart from the remainder and the seconds increment. The carry propagates from bit 31 into bit 32 of the seconds.
- R4: The command code 1 (load) copies the shadow seconds and the low 30 bits of the shadow nanoseconds into the live time. This happens on the clock after the command write, and no step is added on that clock.
- R5: Command code 2 (save) copies the live time into the shadow registers on the clock after the command write. The shadow nanosecond register then reads the 30-bit value with zeros above it. The live clock keeps ticking.
- R6: Command code 3 (offset) adds the shadow nanosecond register, taken as a 32-bit two's-complement number, to the live nanoseconds. The seconds do not change on that clock. A negative result appears on `tod_ns` as its 30-bit two's complement; for example, -780 appears as 0x3FFFFCF4. The next tick borrows one second and adds 1e9.
- R7: The command field (address 0, bits 1:0; 0 means idle) is one-shot. A read issued on the clock that follows the command write returns the pending code. Later reads return 0. Writing code 0 leaves the time untouched.
- R8: When the trim is on, one extra nanosecond is applied each time the accumulated elapsed time reaches the interval. The extra nanosecond is added when the direction bit (address 5, bit 1) is 0 and subtracted when it is 1.
- R9: Bit 30 of the interval register (address 4) picks the unit. When it is 1, the interval counts in nanoseconds and elapsed time grows by STEP_NS per clock. When it is 0, the interval counts in picoseconds and elapsed time grows by STEP_NS*1000 per clock. The interval occupies bits 29:0.
- R10: Trim corrections stop when the enable bit (address 5, bit 0) is 0 or the interval is 0. Writing zero to address 5 turns the trim off.
- R11: A read presents the addressed register on `rd_data` one clock after `rd_en` is high. The registers are: 1 holds the upper seconds in bits 15:0, with zeros above; 2 holds the lower seconds; 3 holds the shadow nanoseconds; 4 holds the interval and unit; 5 holds the trim configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read data, registered |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds, 30-bit field |

## Verification
The trim is exercised with several patterns, each measured as the nanosecond advance over a 50-clock window. The patterns are: trim disabled, five-clock corrections in each direction, the same spacing expressed in picoseconds, a picosecond interval short enough to correct on every clock, a two-clock interval, and a zero interval. Together they separate the direction, the unit selection and both disable conditions. Directed cases load a time just below a second boundary at the 32-bit seconds edge, to expose the carry. A save reads back the pending command and the one-shot clear. A negative offset shows the raw two's-complement field and then the borrow that reaches back across that same seconds edge.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_ADDR_W = 3;
  localparam int UNIT_BIT   = 30;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SAVE  = 2'd2,
    ACT_DELTA = 2'd3
  } tod_act_e;

  localparam logic [REG_ADDR_W-1:0] RA_CTRL     = 3'd0;
  localparam logic [REG_ADDR_W-1:0] RA_SEC_HI   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] RA_SEC_LO   = 3'd2;
  localparam logic [REG_ADDR_W-1:0] RA_NS       = 3'd3;
  localparam logic [REG_ADDR_W-1:0] RA_TRIM_IVL = 3'd4;
  localparam logic [REG_ADDR_W-1:0] RA_TRIM_CFG = 3'd5;
endpackage

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [SEC_W-1:0]      live_sec,
  input  logic [NS_W-1:0]       live_ns,
  output logic [DATA_W-1:0]     rd_data,
  output tod_act_e              act,
  output logic [SEC_W-1:0]      shd_sec,
  output logic [DATA_W-1:0]     shd_ns,
  output logic [NS_W-1:0]       trim_ivl,
  output logic                  trim_unit_ns,
  output logic                  trim_en,
  output logic                  trim_dir
);
  localparam int SEC_HI_W = SEC_W - DATA_W;

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (addr)
      RA_CTRL:     rd_mux[1:0] = act;
      RA_SEC_HI:   rd_mux[SEC_HI_W-1:0] = shd_sec[SEC_W-1:DATA_W];
      RA_SEC_LO:   rd_mux = shd_sec[DATA_W-1:0];
      RA_NS:       rd_mux = shd_ns;
      RA_TRIM_IVL: begin
        rd_mux[NS_W-1:0] = trim_ivl;
        rd_mux[UNIT_BIT] = trim_unit_ns;
      end
      RA_TRIM_CFG: rd_mux[1:0] = {trim_dir, trim_en};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act          <= ACT_IDLE;
      shd_sec      <= '0;
      shd_ns       <= '0;
      trim_ivl     <= '0;
      trim_unit_ns <= 1'b0;
      trim_en      <= 1'b0;
      trim_dir     <= 1'b0;
      rd_data      <= '0;
    end else begin
      if (act != ACT_IDLE) act <= ACT_IDLE;
      if (wr_en) begin
        case (addr)
          RA_CTRL:     act <= tod_act_e'(wr_data[1:0]);
          RA_SEC_HI:   shd_sec[SEC_W-1:DATA_W] <= wr_data[SEC_HI_W-1:0];
          RA_SEC_LO:   shd_sec[DATA_W-1:0] <= wr_data;
          RA_NS:       shd_ns <= wr_data;
          RA_TRIM_IVL: begin
            trim_ivl     <= wr_data[NS_W-1:0];
            trim_unit_ns <= wr_data[UNIT_BIT];
          end
          RA_TRIM_CFG: begin
            trim_en  <= wr_data[0];
            trim_dir <= wr_data[1];
          end
          default: ;
        endcase
      end
      if (act == ACT_SAVE) begin
        shd_sec <= live_sec;
        shd_ns  <= {{(DATA_W-NS_W){1'b0}}, live_ns};
      end
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_oneshot_R7: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_IDLE && !(wr_en && addr == RA_CTRL)) |=> act == ACT_IDLE);

  assert_save_R5: assert property (@(posedge clk) disable iff (rst)
    act == ACT_SAVE |=> (shd_sec == $past(live_sec) && shd_ns[NS_W-1:0] == $past(live_ns)));
endmodule

// File: rtl/ptp_tod_trim.sv
module ptp_tod_trim #(
  parameter int NS_W    = 30,
  parameter int STEP_NS = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            unit_ns,
  input  logic [NS_W-1:0] ivl,
  output logic            fire
);
  localparam int ACC_W = NS_W + 2;
  localparam logic [ACC_W-1:0] ADD_NS = ACC_W'(STEP_NS);
  localparam logic [ACC_W-1:0] ADD_PS = ACC_W'(STEP_NS * 1000);

  logic [ACC_W-1:0] acc_q, add, nxt, rem, ivl_ext;
  logic             active;

  always_comb begin
    ivl_ext = {2'b00, ivl};
    active  = en && (ivl != '0);
    add     = unit_ns ? ADD_NS : ADD_PS;
    nxt     = acc_q + add;
    rem     = nxt - ivl_ext;
    fire    = active && (nxt >= ivl_ext);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) acc_q <= '0;
    else if (fire)      acc_q <= (rem >= ivl_ext) ? '0 : rem;
    else                acc_q <= nxt;
  end

  assert_acc_below_ivl_R8: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && $stable(ivl)) |-> acc_q < ivl_ext);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int STEP_NS    = 20,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  tod_act_e          act,
  input  logic [SEC_W-1:0]  shd_sec,
  input  logic [DATA_W-1:0] shd_ns,
  input  logic              fire,
  input  logic              dir,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns
);
  localparam int NSI_W = NS_W + 2;
  localparam logic signed [NSI_W-1:0] NS_MAX = NSI_W'(NS_PER_SEC);
  localparam logic signed [NSI_W-1:0] STEP_S = NSI_W'(STEP_NS);

  logic signed [NSI_W-1:0] ns_q, inc, sum, ns_n, delta;
  logic [SEC_W-1:0]        sec_q, sec_n;
  logic                    tick;

  always_comb begin
    delta = $signed(shd_ns[NSI_W-1:0]);
    tick  = (act == ACT_IDLE) || (act == ACT_SAVE);
    inc   = STEP_S;
    if (fire) inc = dir ? STEP_S - 1 : STEP_S + 1;
    sum   = ns_q + inc;
    ns_n  = sum;
    sec_n = sec_q;
    if (sum >= NS_MAX) begin
      ns_n  = sum - NS_MAX;
      sec_n = sec_q + SEC_W'(1);
    end else if (sum < 0) begin
      ns_n  = sum + NS_MAX;
      sec_n = sec_q - SEC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      case (act)
        ACT_LOAD: begin
          sec_q <= shd_sec;
          ns_q  <= $signed({2'b00, shd_ns[NS_W-1:0]});
        end
        ACT_DELTA: ns_q <= ns_q + delta;
        default: begin
          ns_q  <= ns_n;
          sec_q <= sec_n;
        end
      endcase
    end
  end

  assign tod_sec = sec_q;
  assign tod_ns  = ns_q[NS_W-1:0];

  assert_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !fire && ns_q >= 0 && ns_q < NS_MAX - STEP_S)
      |=> (ns_q == $past(ns_q) + STEP_S && $stable(sec_q)));

  assert_normalized_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && ns_q > -NS_MAX && ns_q < NS_MAX) |=> (ns_q >= 0 && ns_q < NS_MAX));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LOAD |=> (sec_q == $past(shd_sec) && tod_ns == $past(shd_ns[NS_W-1:0])));

  assert_delta_R6: assert property (@(posedge clk) disable iff (rst)
    act == ACT_DELTA |=> (ns_q == $past(ns_q) + $past(delta) && $stable(sec_q)));
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int STEP_NS    = 20,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  output logic [DATA_W-1:0]     rd_data,
  output logic [SEC_W-1:0]      tod_sec,
  output logic [NS_W-1:0]       tod_ns
);
  tod_act_e          act;
  logic [SEC_W-1:0]  shd_sec;
  logic [DATA_W-1:0] shd_ns;
  logic [NS_W-1:0]   trim_ivl;
  logic              trim_unit_ns, trim_en, trim_dir, fire;

  ptp_tod_regs #(.SEC_W(SEC_W), .NS_W(NS_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .live_sec(tod_sec), .live_ns(tod_ns), .rd_data(rd_data),
    .act(act), .shd_sec(shd_sec), .shd_ns(shd_ns), .trim_ivl(trim_ivl),
    .trim_unit_ns(trim_unit_ns), .trim_en(trim_en), .trim_dir(trim_dir)
  );

  ptp_tod_trim #(.NS_W(NS_W), .STEP_NS(STEP_NS)) trim_i (
    .clk(clk), .rst(rst), .en(trim_en), .unit_ns(trim_unit_ns),
    .ivl(trim_ivl), .fire(fire)
  );

  ptp_tod_counter #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_NS(STEP_NS),
                    .NS_PER_SEC(NS_PER_SEC)) cnt_i (
    .clk(clk), .rst(rst), .act(act), .shd_sec(shd_sec), .shd_ns(shd_ns),
    .fire(fire), .dir(trim_dir), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );
endmodule

// File: tb/ptp_tod_clock_tb_top.sv
module ptp_tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ptp_tod_clock dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  // {interval register, config register, expected advance over 50 clocks}
  localparam logic [63:0] TRIM_VEC [7] = '{
    {32'h4000_0064, 16'h0000, 16'd1000},  // R10 enable off
    {32'h4000_0064, 16'h0001, 16'd1010},  // R8 add every 5 clocks
    {32'h4000_0064, 16'h0003, 16'd990},   // R8 subtract every 5 clocks
    {32'h0001_86A0, 16'h0001, 16'd1010},  // R9 100000 ps
    {32'h0000_0064, 16'h0001, 16'd1050},  // R9 100 ps: every clock
    {32'h4000_0028, 16'h0003, 16'd975},   // R8 subtract every 2 clocks
    {32'h0000_0000, 16'h0001, 16'd1000}   // R10 zero interval
  };

  function automatic string trim_tag(int i);
    case (i)
      0, 6:    return "R10";
      3, 4:    return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic [29:0] a, b;
    logic [47:0] vs;
    longint v, r, n;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sec in reset", {16'h0, tod_sec}, 64'd0);
    chk("R1 ns in reset", {34'h0, tod_ns}, 64'd0);
    chk("R1 rd_data in reset", {32'h0, rd_data}, 64'd0);
    rst = 1'b0;
    rd(3'd0, q); chk("R1 command reg", {32'h0, q}, 64'd0);
    rd(3'd3, q); chk("R1 shadow ns", {32'h0, q}, 64'd0);
    rd(3'd5, q); chk("R1 trim cfg", {32'h0, q}, 64'd0);

    a = tod_ns;
    @(negedge clk);
    chk("R2 nominal step", {34'h0, tod_ns}, {34'h0, a + 30'd20});

    a = tod_ns;
    wr(3'd0, 32'd0);
    chk("R7 idle write no effect", {34'h0, tod_ns}, {34'h0, a + 30'd20});

    for (int i = 0; i < 7; i++) begin
      wr(3'd4, TRIM_VEC[i][63:32]);
      wr(3'd5, {16'h0, TRIM_VEC[i][31:16]});
      wr(3'd0, 32'd1);
      repeat (2) @(negedge clk);
      a = tod_ns;
      repeat (50) @(negedge clk);
      b = tod_ns;
      chk($sformatf("%s trim row %0d", trim_tag(i), i),
          {34'h0, b - a}, {48'h0, TRIM_VEC[i][15:0]});
    end

    rd(3'd4, q); chk("R11 interval readback", {32'h0, q}, 64'd0);
    wr(3'd4, 32'h4000_0028);
    rd(3'd4, q); chk("R11 interval and unit readback", {32'h0, q}, 64'h4000_0028);
    wr(3'd5, 32'd0);
    rd(3'd5, q); chk("R10 trim cfg cleared", {32'h0, q}, 64'd0);

    wr(3'd1, 32'hABCD_0000);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'd999_999_990);
    rd(3'd1, q); chk("R11 upper seconds masked", {32'h0, q}, 64'd0);
    wr(3'd0, 32'd1);
    @(negedge clk);
    chk("R4 load seconds", {16'h0, tod_sec}, 64'h0000_0000_FFFF_FFFF);
    chk("R4 load ns", {34'h0, tod_ns}, 64'd999_999_990);
    @(negedge clk);
    chk("R3 ns wrap", {34'h0, tod_ns}, 64'd10);
    chk("R3 seconds carry", {16'h0, tod_sec}, 64'h0000_0001_0000_0000);

    wr(3'd0, 32'd2);
    vs = tod_sec; a = tod_ns;
    rd(3'd0, q); chk("R7 pending save visible", {32'h0, q}, 64'd2);
    rd(3'd0, q); chk("R7 command cleared", {32'h0, q}, 64'd0);
    rd(3'd1, q); chk("R5 saved upper seconds", {32'h0, q}, {48'h0, vs[47:32]});
    rd(3'd2, q); chk("R5 saved lower seconds", {32'h0, q}, {32'h0, vs[31:0]});
    rd(3'd3, q); chk("R5 saved ns", {32'h0, q}, {34'h0, a});

    wr(3'd3, 32'hFFFF_FC18);
    v  = longint'(tod_ns);
    vs = tod_sec;
    wr(3'd0, 32'd3);
    @(negedge clk);
    r = v + 20 - 1000;
    chk("R6 raw negative ns", {34'h0, tod_ns}, {34'h0, r[29:0]});
    chk("R6 seconds held", {16'h0, tod_sec}, {16'h0, vs});
    @(negedge clk);
    n = r + 20;
    if (n < 0) begin
      n = n + 1_000_000_000;
      vs = vs - 48'd1;
    end
    chk("R6 borrow ns", {34'h0, tod_ns}, {34'h0, n[29:0]});
    chk("R6 borrow seconds", {16'h0, tod_sec}, {16'h0, vs});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule